// File: doc/BRIEF.md
# Serial Receive Status and Interrupt Logic

This block is the receive back end of an asynchronous serial port. A receive shifter, which is not part of this block, reports a finished character as a one-cycle `char_valid` pulse, together with the byte and a noise bit and a framing bit for that character. The block holds that character until the next receiver bit-rate tick and then moves it into a data register that the processor reads. It also keeps five status flags (data full, overrun, noise, framing, idle) and drives two interrupt lines, each with its own enable.

Three small state machines do the work. The transfer machine has two states, XF_EMPTY and XF_HELD. A captured character moves it from XF_EMPTY to XF_HELD. A bit tick moves it from XF_HELD back to XF_EMPTY and moves the character into the data register. It stays in XF_HELD when a new character arrives on the same tick, and it drops to XF_EMPTY when the receiver is disabled. The idle-arm machine goes from IA_DISARMED to IA_ARMED on each transfer and back to IA_DISARMED when the flags are cleared. While armed, ten consecutive bit ticks with the line high set the idle flag. The clear machine goes from CS_WAIT to CS_STAT_SEEN on a status read. A data read in CS_STAT_SEEN clears all flags and returns it to CS_WAIT. Further status reads keep it in CS_STAT_SEEN.

Top module: `uart_rx_status`

## Requirements
- R1: After reset all five status flags, the data register and both interrupt outputs are 0.
- R2: A character reported by `char_valid` reaches `data_out` and sets the full flag (status bit 0) only on the clock edge where `bit_tick` is high. It never does so on the capture edge itself.
- R3: `data_out` shows the last loaded byte while `rx_en` is 1 and shows 0 while `rx_en` is 0. The stored byte is kept in both cases.
- R4: On a load, the noise flag (bit 2) and the framing flag (bit 3) take the noise and framing indications of the loaded character.
- R5: When a character is transferred while the full flag is set, the overrun flag (bit 1) is set and `data_out` keeps the earlier byte.
- R6: `rx_irq` is high exactly when the full flag and `rie` are both 1.
- R7: After a transferred character, the idle flag (bit 4) sets one clock after the tenth consecutive `bit_tick` with `rx_line` high, and not before.
- R8: The idle flag never sets unless a character has been transferred since reset or since the last flag clear.
- R9: `idle_irq` is high exactly when the idle flag and `ilie` are both 1.
- R10: A `rd_status` pulse followed later by a `rd_data` pulse clears all flags and the idle arm. A `rd_data` pulse with no status read before it changes nothing.
- R11: While `rx_en` is 0, no character is captured or transferred, no flag sets, and a character held when `rx_en` falls is discarded.
- R12: Any cycle with `rx_line` low restarts the count of idle ticks from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| bit_tick | input | 1 | Receiver bit-rate tick, one cycle wide |
| rx_line | input | 1 | Receive line level |
| char_valid | input | 1 | Shifter has finished a character |
| char_data | input | 8 | Finished character byte |
| char_noise | input | 1 | Noise seen on this character |
| char_frame | input | 1 | Stop bit of this character was bad |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle-line interrupt enable |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| data_out | output | 8 | Data register contents |
| status_out | output | 5 | {idle, frame, noise, overrun, full} |
| rx_irq | output | 1 | Receive interrupt |
| idle_irq | output | 1 | Idle-line interrupt |

## Verification
A transfer machine stuck in XF_HELD shows up on the first later tick as a second load or as a false overrun. A machine that never leaves XF_EMPTY leaves the full flag low one tick after a character. A wrong idle-arm state shows up ten ticks after a character as a missing idle flag, or as an idle flag during a quiet line after a clear. A clear machine that skips CS_STAT_SEEN shows up on a lone data read, when the flags drop in the very next cycle.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int ST_FULL  = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_NOISE = 2;
    localparam int ST_FRAME = 3;
    localparam int ST_IDLE  = 4;
    localparam int ST_W     = 5;

    typedef enum logic {XF_EMPTY, XF_HELD}        xf_state_e;
    typedef enum logic {IA_DISARMED, IA_ARMED}    ia_state_e;
    typedef enum logic {CS_WAIT, CS_STAT_SEEN}    cs_state_e;
endpackage

// File: rtl/urx_xfer_fsm.sv
module urx_xfer_fsm
    import urx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_tick,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              char_frame,
    output logic              xfer_go,
    output logic [DATA_W-1:0] xfer_data,
    output logic              xfer_noise,
    output logic              xfer_frame
);
    xf_state_e state_q, state_d;
    logic [DATA_W-1:0] held_data_q;
    logic              held_noise_q;
    logic              held_frame_q;
    logic              capture;

    assign capture = rx_en && char_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_EMPTY: if (capture) state_d = XF_HELD;
            XF_HELD: begin
                if (!rx_en)                       state_d = XF_EMPTY;
                else if (bit_tick && !char_valid) state_d = XF_EMPTY;
            end
            default: state_d = XF_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_data_q  <= '0;
            held_noise_q <= 1'b0;
            held_frame_q <= 1'b0;
        end else if (capture) begin
            held_data_q  <= char_data;
            held_noise_q <= char_noise;
            held_frame_q <= char_frame;
        end
    end

    always_comb begin
        xfer_go    = (state_q == XF_HELD) && rx_en && bit_tick;
        xfer_data  = held_data_q;
        xfer_noise = held_noise_q;
        xfer_frame = held_frame_q;
    end

    AST_GO_ONLY_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> (state_q == XF_HELD) && !$past(!rx_en && (state_q == XF_EMPTY)))
        else $error("transfer without held character"); // R11
endmodule

// File: rtl/urx_idle_det.sv
module urx_idle_det
    import urx_pkg::*;
#(
    parameter int IDLE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic rx_line,
    input  logic bit_tick,
    input  logic arm_evt,
    input  logic disarm_evt,
    output logic armed,
    output logic idle_hit
);
    localparam int CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_TICKS);

    ia_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!rx_line || !rx_en)         cnt_q <= '0;
        else if (bit_tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IA_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IA_DISARMED: if (arm_evt)                  state_d = IA_ARMED;
            IA_ARMED:    if (disarm_evt && !arm_evt)   state_d = IA_DISARMED;
            default:     state_d = IA_DISARMED;
        endcase
    end

    always_comb begin
        armed    = (state_q == IA_ARMED);
        idle_hit = armed && rx_en && (cnt_q == CNT_MAX);
    end

    AST_LOW_LINE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_line |=> (cnt_q == '0) || (rx_line && $past(rx_line) == 1'b0 && cnt_q <= 1))
        else $error("idle count not restarted"); // R12
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1))
        else $error("idle count jumped"); // R7
endmodule

// File: rtl/urx_clr_fsm.sv
module urx_clr_fsm
    import urx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_status,
    input  logic rd_data,
    output logic clr_pulse
);
    cs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_WAIT:      if (rd_status) state_d = CS_STAT_SEEN;
            CS_STAT_SEEN: if (rd_data && !rd_status) state_d = CS_WAIT;
            default:      state_d = CS_WAIT;
        endcase
    end

    always_comb begin
        clr_pulse = (state_q == CS_STAT_SEEN) && rd_data;
    end
endmodule

// File: rtl/urx_flags.sv
module urx_flags
    import urx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_go,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_noise,
    input  logic              xfer_frame,
    input  logic              idle_hit,
    input  logic              clr_pulse,
    input  logic              rd_data,
    output logic [DATA_W-1:0] data_q,
    output logic [ST_W-1:0]   flags_q
);
    logic overrun_evt;
    logic load_evt;

    assign overrun_evt = xfer_go && flags_q[ST_FULL] && !clr_pulse;
    assign load_evt    = xfer_go && !overrun_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            if (clr_pulse) flags_q <= '0;
            if (overrun_evt) flags_q[ST_OVR] <= 1'b1;
            if (load_evt) begin
                data_q            <= xfer_data;
                flags_q[ST_FULL]  <= 1'b1;
                flags_q[ST_NOISE] <= xfer_noise;
                flags_q[ST_FRAME] <= xfer_frame;
            end
            if (idle_hit && !clr_pulse) flags_q[ST_IDLE] <= 1'b1;
        end
    end

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[ST_OVR]) |-> $past(flags_q[ST_FULL]))
        else $error("overrun without full"); // R5
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[ST_OVR]) |-> $stable(data_q))
        else $error("overrun replaced data"); // R5
    AST_FULL_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q[ST_FULL]) |-> $past(rd_data))
        else $error("full cleared without data read"); // R10
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import urx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IDLE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              char_frame,
    input  logic              rie,
    input  logic              ilie,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic [DATA_W-1:0] data_out,
    output logic [ST_W-1:0]   status_out,
    output logic              rx_irq,
    output logic              idle_irq
);
    logic              xfer_go;
    logic [DATA_W-1:0] xfer_data;
    logic              xfer_noise;
    logic              xfer_frame;
    logic              armed;
    logic              idle_hit;
    logic              clr_pulse;
    logic [DATA_W-1:0] data_q;
    logic [ST_W-1:0]   flags_q;

    urx_xfer_fsm #(.DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
        .char_valid(char_valid), .char_data(char_data),
        .char_noise(char_noise), .char_frame(char_frame),
        .xfer_go(xfer_go), .xfer_data(xfer_data),
        .xfer_noise(xfer_noise), .xfer_frame(xfer_frame)
    );

    urx_idle_det #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line),
        .bit_tick(bit_tick), .arm_evt(xfer_go), .disarm_evt(clr_pulse),
        .armed(armed), .idle_hit(idle_hit)
    );

    urx_clr_fsm u_clr (
        .clk(clk), .rst_n(rst_n), .rd_status(rd_status), .rd_data(rd_data),
        .clr_pulse(clr_pulse)
    );

    urx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_data(xfer_data),
        .xfer_noise(xfer_noise), .xfer_frame(xfer_frame), .idle_hit(idle_hit),
        .clr_pulse(clr_pulse), .rd_data(rd_data),
        .data_q(data_q), .flags_q(flags_q)
    );

    always_comb begin
        data_out   = rx_en ? data_q : '0;
        status_out = flags_q;
        rx_irq     = rie  && flags_q[ST_FULL];
        idle_irq   = ilie && flags_q[ST_IDLE];
    end

    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_out[ST_FULL]) |-> $past(bit_tick))
        else $error("load without tick"); // R2
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ((status_out & ~$past(status_out)) == '0))
        else $error("flag set while disabled"); // R11
    AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_out[ST_IDLE]) |-> $past(armed))
        else $error("idle without character"); // R8
    AST_RXIRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rie && status_out[ST_FULL])
        else $error("receive interrupt without cause"); // R6
endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       bit_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_noise = 1'b0;
    logic       char_frame = 1'b0;
    logic       rie = 1'b0;
    logic       ilie = 1'b0;
    logic       rd_status = 1'b0;
    logic       rd_data = 1'b0;
    logic [7:0] data_out;
    logic [4:0] status_out;
    logic       rx_irq;
    logic       idle_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_status u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
        .rx_line(rx_line), .char_valid(char_valid), .char_data(char_data),
        .char_noise(char_noise), .char_frame(char_frame), .rie(rie), .ilie(ilie),
        .rd_status(rd_status), .rd_data(rd_data), .data_out(data_out),
        .status_out(status_out), .rx_irq(rx_irq), .idle_irq(idle_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_char(input logic [7:0] d, input logic n, input logic f);
        @(negedge clk);
        rx_line = 1'b0; char_valid = 1'b1; char_data = d; char_noise = n; char_frame = f;
        @(negedge clk);
        rx_line = 1'b1; char_valid = 1'b0;
    endtask

    task automatic clear_seq();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) begin rd_status = 1'b0; rd_data = 1'b1; end
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic line_low();
        @(negedge clk) rx_line = 1'b0;
        @(negedge clk) rx_line = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", 32'(status_out), 0);
        chk("R1 data", 32'(data_out), 0);
        chk("R1 irqs", 32'({rx_irq, idle_irq}), 0);

        // Sweep every byte with every noise/frame combination
        for (int d = 0; d < 256; d++) begin
            for (int nf = 0; nf < 4; nf++) begin
                rie = d[0];
                send_char(8'(d), nf[0], nf[1]);
                chk("R2 not yet full", 32'(status_out[0]), 0);
                tick();
                chk("R2 full after tick", 32'(status_out[0]), 1);
                chk("R3 data", 32'(data_out), 32'(d));
                chk("R4 noise", 32'(status_out[2]), 32'(nf[0]));
                chk("R4 frame", 32'(status_out[3]), 32'(nf[1]));
                chk("R6 rx_irq", 32'(rx_irq), 32'(d[0]));
                clear_seq();
                chk("R10 cleared", 32'(status_out), 0);
                chk("R6 rx_irq low", 32'(rx_irq), 0);
            end
        end

        // Overrun
        send_char(8'h11, 1'b0, 1'b0); tick();
        send_char(8'h22, 1'b0, 1'b0); tick();
        chk("R5 overrun", 32'(status_out[1:0]), 32'h3);
        chk("R5 data kept", 32'(data_out), 32'h11);
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
        chk("R10 lone data read", 32'(status_out[1:0]), 32'h3);
        clear_seq();
        chk("R10 clear after overrun", 32'(status_out), 0);
        send_char(8'h22, 1'b1, 1'b0); tick();
        chk("R5 load after clear", 32'(data_out), 32'h22);
        clear_seq();

        // Idle
        ticks(12);
        chk("R8 no idle without char", 32'(status_out[4]), 0);
        send_char(8'h5A, 1'b0, 1'b0);
        ticks(9);
        chk("R7 idle after nine ticks", 32'(status_out[4]), 0);
        tick();
        @(negedge clk);
        chk("R7 idle after ten ticks", 32'(status_out[4]), 1);
        ilie = 1'b0; #1;
        chk("R9 idle_irq disabled", 32'(idle_irq), 0);
        ilie = 1'b1; #1;
        chk("R9 idle_irq enabled", 32'(idle_irq), 1);
        clear_seq();
        chk("R10 idle cleared", 32'(status_out[4]), 0);
        ticks(12);
        chk("R8 arm cleared", 32'(status_out[4]), 0);

        // Line low restarts idle count
        send_char(8'hA5, 1'b0, 1'b0);
        ticks(6);
        line_low();
        ticks(9);
        @(negedge clk);
        chk("R12 restart", 32'(status_out[4]), 0);
        tick();
        @(negedge clk);
        chk("R12 idle after fresh ten", 32'(status_out[4]), 1);
        clear_seq();
        ilie = 1'b0;

        // Receiver disabled
        send_char(8'hC3, 1'b0, 1'b0); tick();
        clear_seq();
        rx_en = 1'b0; #1;
        chk("R3 disabled data", 32'(data_out), 0);
        send_char(8'h3C, 1'b1, 1'b1); tick();
        ticks(12);
        chk("R11 no flags", 32'(status_out), 0);
        rx_en = 1'b1; #1;
        chk("R11 data unchanged", 32'(data_out), 32'hC3);
        send_char(8'h77, 1'b0, 1'b0);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        tick();
        chk("R11 held char dropped", 32'(status_out[0]), 0);
        chk("R11 data after drop", 32'(data_out), 32'hC3);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule